// File: doc/BRIEF.md
# Multi-Source Reset Controller with Cause Latching

This block turns a set of reset requests into three reset outputs: a power-on-class reset, a hardware-class reset and a software reset. It also raises a non-maskable interrupt when the watchdog is configured for that. An active-high external reset line and one selectable GPIO, with programmable polarity, form the power-on source. The block times how long that source stays active. A hold that reaches the programmed delay produces a power-on-class reset. An external pulse that ends before the delay produces only a hardware reset. A software request bit, a watchdog expiry and a wake-from-sleep event give the other reset paths.

The controller's own flip-flops are reset asynchronously whenever any supply-good input is low. That condition also holds all three reset outputs active. Every reset output stays active for at least four clock cycles and is released on a clock edge. A four-bit sticky cause register records why resets happened. Software clears its bits by writing ones. All control and status pins are plain levels or single-cycle pulses with no handshake. The external and GPIO inputs are synchronised inside the block. The other request inputs must already be synchronous to `clk`.

Top module: `reset_cause_ctrl`

## Requirements
- R1: While any bit of `supply_ok` is low, `por_rst_o`, `hw_rst_o` and `sw_rst_o` are high and `status_o` reads 4'b1111. Once all bits are high, the three outputs fall exactly HOLD_CYC (default 4) clock edges later.
- R2: If the power-on source stays active for `por_delay` consecutive synchronised cycles, `por_rst_o` and `hw_rst_o` are asserted and all four status bits are set. A hold one cycle shorter does not assert `por_rst_o`.
- R3: If `ext_rst_i` goes high and then low before the power-on delay completes, `hw_rst_o` is asserted, `por_rst_o` is not, and status bit 1 (hardware) is set.
- R4: When `gpio_src_en` is 1, the GPIO indexed by `gpio_src_sel` is a power-on source and is active when it equals `gpio_src_pol`. When `gpio_src_en` is 0, or the level does not match, it produces no reset.
- R5: A `por_delay` of zero disables the power-on path. An external hold of any length then gives only a hardware reset.
- R6: When `hwr_disable` is 1, a short external pulse produces no reset and sets no status bit.
- R7: A one-cycle `sw_rst_req` asserts `sw_rst_o` for exactly HOLD_CYC cycles, sets status bit 2 (software), and leaves `hw_rst_o` and `por_rst_o` low.
- R8: A one-cycle `wdog_expire` with `wdog_to_nmi` = 0 asserts `hw_rst_o` and sets status bit 3 (watchdog). With `wdog_to_nmi` = 1 it produces a one-cycle `nmi_o`, no reset, and no status change.
- R9: A `wake_event` asserts `hw_rst_o` and sets status bit 1 when `rst_on_wake` is 1. It has no effect when `rst_on_wake` is 0.
- R10: Status bits are sticky and accumulate. A cycle with `status_clr_we` high clears the bits that are 1 in `status_clr`. A bit being set in the same cycle stays set.
- R11: Each reset output, once asserted, stays high for at least 4 cycles. `por_rst_o` high always implies `hw_rst_o` high.
- R12: `ext_rst_i` and the selected GPIO pass through SYNC_STAGES flip-flops before they are timed, so a hold of N input cycles counts as N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| supply_ok | input | N_SUPPLY | Supply-good flags; any low resets the block |
| ext_rst_i | input | 1 | External reset request, active high |
| gpio_i | input | GPIO_W | GPIO levels |
| gpio_src_en | input | 1 | Enable the GPIO as a power-on source |
| gpio_src_sel | input | clog2(GPIO_W) | Index of the GPIO used as a source |
| gpio_src_pol | input | 1 | Active level of the selected GPIO |
| por_delay | input | DLY_W | Power-on hold threshold in cycles; 0 disables |
| hwr_disable | input | 1 | Suppress hardware reset from a short external pulse |
| sw_rst_req | input | 1 | Software reset request pulse |
| wdog_expire | input | 1 | Watchdog timeout pulse |
| wdog_to_nmi | input | 1 | Route watchdog timeout to NMI instead of reset |
| wake_event | input | 1 | Wake-from-sleep pulse |
| rst_on_wake | input | 1 | Issue a hardware reset on wake |
| status_clr_we | input | 1 | Write strobe for status clearing |
| status_clr | input | 4 | Write-one-to-clear mask |
| por_rst_o | output | 1 | Power-on-class reset |
| hw_rst_o | output | 1 | Hardware-class reset |
| sw_rst_o | output | 1 | Software reset |
| nmi_o | output | 1 | Watchdog NMI pulse |
| status_o | output | 4 | Cause bits: [0] power-on, [1] hardware, [2] software, [3] watchdog |

## Verification
On every cycle the assertions check these rules: the minimum four-cycle width of each reset output, that power-on implies hardware reset, that a power-on reset sets every cause bit, that a software request is recorded and beats a same-cycle clear, and that NMI only follows a watchdog expiry routed to it. Only the directed scenarios can show some other behaviours. These are the exact hold length that separates a hardware reset from a power-on reset, the effect of polarity and source selection on the GPIO, that a zero delay or the disable bit suppress their paths, and the exact release cycle after the supplies come up.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int CAUSE_W  = 4;
  localparam int C_POR    = 0;
  localparam int C_HW     = 1;
  localparam int C_SW     = 2;
  localparam int C_WDOG   = 3;
  localparam int MIN_HOLD = 4;

  typedef struct packed {
    logic wdog;
    logic sw;
    logic hw;
    logic por;
  } rcc_evt_t;
endpackage

// File: rtl/rcc_sync.sv
module rcc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[s] <= '0;
          else        stage[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[s] <= '0;
          else        stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/rcc_hold_classifier.sv
module rcc_hold_classifier #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_s,
  input  logic             src_s,
  input  logic [DLY_W-1:0] por_delay,
  output logic             por_fire,
  output logic             ext_short
);
  logic [DLY_W-1:0] hold_cnt;
  logic             ext_q;
  logic             por_seen;
  logic             dly_on;

  assign dly_on    = (por_delay != '0);
  assign por_fire  = src_s && dly_on && (hold_cnt == por_delay - 1'b1);
  assign ext_short = ext_q && !ext_s && !por_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      ext_q    <= 1'b0;
      por_seen <= 1'b0;
    end else begin
      ext_q <= ext_s;
      if (!src_s) begin
        hold_cnt <= '0;
        por_seen <= 1'b0;
      end else begin
        if (hold_cnt != '1) hold_cnt <= hold_cnt + 1'b1;
        if (por_fire)       por_seen <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rcc_stretch.sv
module rcc_stretch #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic active
);
  localparam int CW = $clog2(HOLD + 1);
  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= CW'(HOLD);
    else if (trig)           remain <= CW'(HOLD);
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign active = (remain != '0);
endmodule

// File: rtl/rcc_cause_reg.sv
module rcc_cause_reg
  import rcc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  rcc_evt_t           evt,
  input  logic               clr_we,
  input  logic [CAUSE_W-1:0] clr_mask,
  output logic [CAUSE_W-1:0] cause
);
  logic [CAUSE_W-1:0] set_v;
  logic [CAUSE_W-1:0] keep_v;

  always_comb begin
    set_v         = '0;
    set_v[C_HW]   = evt.hw;
    set_v[C_SW]   = evt.sw;
    set_v[C_WDOG] = evt.wdog;
    if (evt.por) set_v = '1;
    keep_v = clr_we ? (cause & ~clr_mask) : cause;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause <= '1;
    else        cause <= keep_v | set_v;
  end
endmodule

// File: rtl/reset_cause_ctrl.sv
module reset_cause_ctrl
  import rcc_pkg::*;
#(
  parameter int N_SUPPLY    = 3,
  parameter int GPIO_W      = 8,
  parameter int DLY_W       = 8,
  parameter int HOLD_CYC    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic [N_SUPPLY-1:0]       supply_ok,
  input  logic                      ext_rst_i,
  input  logic [GPIO_W-1:0]         gpio_i,
  input  logic                      gpio_src_en,
  input  logic [$clog2(GPIO_W)-1:0] gpio_src_sel,
  input  logic                      gpio_src_pol,
  input  logic [DLY_W-1:0]          por_delay,
  input  logic                      hwr_disable,
  input  logic                      sw_rst_req,
  input  logic                      wdog_expire,
  input  logic                      wdog_to_nmi,
  input  logic                      wake_event,
  input  logic                      rst_on_wake,
  input  logic                      status_clr_we,
  input  logic [CAUSE_W-1:0]        status_clr,
  output logic                      por_rst_o,
  output logic                      hw_rst_o,
  output logic                      sw_rst_o,
  output logic                      nmi_o,
  output logic [CAUSE_W-1:0]        status_o
);
  localparam int HOLD_EFF = (HOLD_CYC < MIN_HOLD) ? MIN_HOLD : HOLD_CYC;

  logic       pwr_good;
  logic       gpio_act;
  logic [1:0] raw_req;
  logic [1:0] syn_req;
  logic       ext_s;
  logic       src_s;
  logic       por_fire;
  logic       ext_short;
  logic       hw_from_ext;
  logic       hw_from_wake;
  logic       wdog_rst;
  logic       nmi_q;
  rcc_evt_t   evt;
  logic [2:0] trig;
  logic [2:0] outs;

  assign pwr_good = &supply_ok;
  assign gpio_act = gpio_src_en && (gpio_i[gpio_src_sel] == gpio_src_pol);
  assign raw_req  = {gpio_act, ext_rst_i};

  rcc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (pwr_good),
    .d     (raw_req),
    .q     (syn_req)
  );

  assign ext_s = syn_req[0];
  assign src_s = syn_req[0] | syn_req[1];

  rcc_hold_classifier #(.DLY_W(DLY_W)) u_class (
    .clk       (clk),
    .rst_n     (pwr_good),
    .ext_s     (ext_s),
    .src_s     (src_s),
    .por_delay (por_delay),
    .por_fire  (por_fire),
    .ext_short (ext_short)
  );

  assign hw_from_ext  = ext_short && !hwr_disable;
  assign hw_from_wake = wake_event && rst_on_wake;
  assign wdog_rst     = wdog_expire && !wdog_to_nmi;

  always_comb begin
    evt.por  = por_fire;
    evt.hw   = hw_from_ext | hw_from_wake;
    evt.sw   = sw_rst_req;
    evt.wdog = wdog_rst;
  end

  assign trig[0] = por_fire;
  assign trig[1] = por_fire | hw_from_ext | hw_from_wake | wdog_rst;
  assign trig[2] = sw_rst_req;

  generate
    for (genvar i = 0; i < 3; i++) begin : g_line
      rcc_stretch #(.HOLD(HOLD_EFF)) u_stretch (
        .clk    (clk),
        .rst_n  (pwr_good),
        .trig   (trig[i]),
        .active (outs[i])
      );
    end
  endgenerate

  assign por_rst_o = outs[0];
  assign hw_rst_o  = outs[1];
  assign sw_rst_o  = outs[2];

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) nmi_q <= 1'b0;
    else           nmi_q <= wdog_expire && wdog_to_nmi;
  end
  assign nmi_o = nmi_q;

  rcc_cause_reg u_cause (
    .clk      (clk),
    .rst_n    (pwr_good),
    .evt      (evt),
    .clr_we   (status_clr_we),
    .clr_mask (status_clr),
    .cause    (status_o)
  );
endmodule

// File: rtl/reset_cause_ctrl_chk.sv
module reset_cause_ctrl_chk (
  input logic       clk,
  input logic       pwr_good,
  input logic       por_rst_o,
  input logic       hw_rst_o,
  input logic       sw_rst_o,
  input logic       nmi_o,
  input logic       sw_rst_req,
  input logic       wdog_expire,
  input logic       wdog_to_nmi,
  input logic [3:0] status_o
);
  AST_POR_WITH_HW: assert property (@(posedge clk) disable iff (!pwr_good)
    por_rst_o |-> hw_rst_o); // R11
  AST_POR_MIN_HOLD: assert property (@(posedge clk) disable iff (!pwr_good)
    $fell(por_rst_o) |-> ($past(por_rst_o, 2) && $past(por_rst_o, 3) && $past(por_rst_o, 4))); // R11
  AST_HW_MIN_HOLD: assert property (@(posedge clk) disable iff (!pwr_good)
    $fell(hw_rst_o) |-> ($past(hw_rst_o, 2) && $past(hw_rst_o, 3) && $past(hw_rst_o, 4))); // R11
  AST_SW_MIN_HOLD: assert property (@(posedge clk) disable iff (!pwr_good)
    $fell(sw_rst_o) |-> ($past(sw_rst_o, 2) && $past(sw_rst_o, 3) && $past(sw_rst_o, 4))); // R11
  AST_POR_SETS_ALL: assert property (@(posedge clk) disable iff (!pwr_good)
    $rose(por_rst_o) |-> (status_o == 4'hF)); // R2
  AST_SW_CAUSE_SET: assert property (@(posedge clk) disable iff (!pwr_good)
    $past(sw_rst_req) |-> status_o[2]); // R7
  AST_NMI_ROUTED: assert property (@(posedge clk) disable iff (!pwr_good)
    nmi_o |-> $past(wdog_expire && wdog_to_nmi)); // R8
endmodule

bind reset_cause_ctrl reset_cause_ctrl_chk u_chk (
  .clk         (clk),
  .pwr_good    (&supply_ok),
  .por_rst_o   (por_rst_o),
  .hw_rst_o    (hw_rst_o),
  .sw_rst_o    (sw_rst_o),
  .nmi_o       (nmi_o),
  .sw_rst_req  (sw_rst_req),
  .wdog_expire (wdog_expire),
  .wdog_to_nmi (wdog_to_nmi),
  .status_o    (status_o)
);

// File: tb/reset_cause_ctrl_bench.sv
module reset_cause_ctrl_bench;
  logic       clk = 1'b0;
  logic [2:0] supply_ok;
  logic       ext_rst_i;
  logic [7:0] gpio_i;
  logic       gpio_src_en;
  logic [2:0] gpio_src_sel;
  logic       gpio_src_pol;
  logic [7:0] por_delay;
  logic       hwr_disable, sw_rst_req, wdog_expire, wdog_to_nmi;
  logic       wake_event, rst_on_wake, status_clr_we;
  logic [3:0] status_clr;
  logic       por_rst_o, hw_rst_o, sw_rst_o, nmi_o;
  logic [3:0] status_o;

  int checks = 0;
  int errors = 0;
  int n_por = 0, n_hw = 0, n_sw = 0, n_nmi = 0;
  int b_por, b_hw, b_sw, b_nmi;

  always #10 clk = ~clk;

  reset_cause_ctrl u_reset_cause_ctrl (
    .clk(clk), .supply_ok(supply_ok), .ext_rst_i(ext_rst_i), .gpio_i(gpio_i),
    .gpio_src_en(gpio_src_en), .gpio_src_sel(gpio_src_sel), .gpio_src_pol(gpio_src_pol),
    .por_delay(por_delay), .hwr_disable(hwr_disable), .sw_rst_req(sw_rst_req),
    .wdog_expire(wdog_expire), .wdog_to_nmi(wdog_to_nmi), .wake_event(wake_event),
    .rst_on_wake(rst_on_wake), .status_clr_we(status_clr_we), .status_clr(status_clr),
    .por_rst_o(por_rst_o), .hw_rst_o(hw_rst_o), .sw_rst_o(sw_rst_o), .nmi_o(nmi_o),
    .status_o(status_o)
  );

  always @(negedge clk) begin
    if (por_rst_o) n_por++;
    if (hw_rst_o)  n_hw++;
    if (sw_rst_o)  n_sw++;
    if (nmi_o)     n_nmi++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mark();
    b_por = n_por; b_hw = n_hw; b_sw = n_sw; b_nmi = n_nmi;
  endtask

  task automatic clear_status();
    status_clr_we = 1'b1; status_clr = 4'hF;
    run(1);
    status_clr_we = 1'b0; status_clr = 4'h0;
  endtask

  task automatic pulse_ext(input int k);
    ext_rst_i = 1'b1;
    run(k);
    ext_rst_i = 1'b0;
    run(16);
  endtask

  task automatic t_power_up();
    chk(por_rst_o && hw_rst_o && sw_rst_o, "R1 held while supply low", por_rst_o, 1);
    chk(status_o == 4'hF, "R1 status in power-down", status_o, 15);
    supply_ok = 3'b011;
    run(3);
    chk(por_rst_o == 1'b1, "R1 partial supply keeps reset", por_rst_o, 1);
    supply_ok = 3'b111;
    run(3);
    chk(por_rst_o == 1'b1, "R1 still held 3 edges after supply", por_rst_o, 1);
    run(1);
    chk(!por_rst_o && !hw_rst_o && !sw_rst_o, "R1 release at 4th edge", por_rst_o, 0);
    clear_status();
    chk(status_o == 4'h0, "R10 write-one clears all", status_o, 0);
  endtask

  task automatic t_threshold();
    por_delay = 8'd6;
    mark(); pulse_ext(5);
    chk(n_por == b_por, "R2 hold of delay-1 gives no power-on", n_por - b_por, 0);
    chk(n_hw > b_hw, "R3 short pulse gives hw reset", n_hw - b_hw, 4);
    chk(status_o == 4'b0010, "R3 hw cause bit", status_o, 2);
    clear_status();
    mark(); pulse_ext(6);
    chk(n_por > b_por, "R2 hold of delay gives power-on", n_por - b_por, 4);
    chk(status_o == 4'hF, "R2 power-on sets all causes", status_o, 15);
    clear_status();
    mark(); pulse_ext(2);
    chk(n_hw - b_hw == 4, "R12 synchronised short pulse, hw length", n_hw - b_hw, 4);
    clear_status();
  endtask

  task automatic t_gpio();
    por_delay = 8'd6;
    gpio_i = 8'hFF; gpio_src_sel = 3'd2; gpio_src_pol = 1'b0; gpio_src_en = 1'b1;
    run(4);
    mark();
    gpio_i[2] = 1'b0; run(10); gpio_i[2] = 1'b1; run(12);
    chk(n_por > b_por, "R4 gpio active-low source", n_por - b_por, 4);
    chk(status_o == 4'hF, "R4 gpio power-on cause", status_o, 15);
    clear_status();
    mark();
    gpio_i[5] = 1'b0; run(10); gpio_i[5] = 1'b1; run(12);
    chk(n_por == b_por && n_hw == b_hw, "R4 unselected gpio ignored", n_por - b_por, 0);
    gpio_src_en = 1'b0;
    mark();
    gpio_i[2] = 1'b0; run(10); gpio_i[2] = 1'b1; run(12);
    chk(n_por == b_por, "R4 disabled gpio ignored", n_por - b_por, 0);
    chk(status_o == 4'h0, "R4 disabled gpio no cause", status_o, 0);
  endtask

  task automatic t_delay_zero();
    por_delay = 8'd0;
    mark(); pulse_ext(40);
    chk(n_por == b_por, "R5 zero delay no power-on", n_por - b_por, 0);
    chk(n_hw - b_hw == 4, "R5 zero delay gives hw", n_hw - b_hw, 4);
    chk(status_o == 4'b0010, "R5 hw cause only", status_o, 2);
    clear_status();
    por_delay = 8'd6;
  endtask

  task automatic t_hwr_disable();
    hwr_disable = 1'b1;
    mark(); pulse_ext(3);
    chk(n_hw == b_hw, "R6 disabled short pulse no reset", n_hw - b_hw, 0);
    chk(status_o == 4'h0, "R6 disabled short pulse no cause", status_o, 0);
    mark(); pulse_ext(8);
    chk(n_por > b_por, "R6 power-on path still works", n_por - b_por, 4);
    clear_status();
    hwr_disable = 1'b0;
  endtask

  task automatic t_software();
    mark();
    sw_rst_req = 1'b1; run(1); sw_rst_req = 1'b0; run(10);
    chk(n_sw - b_sw == 4, "R7 sw reset length", n_sw - b_sw, 4);
    chk(n_hw == b_hw && n_por == b_por, "R7 sw leaves hw/por", n_hw - b_hw, 0);
    chk(status_o == 4'b0100, "R7 sw cause", status_o, 4);
    chk(n_sw - b_sw >= 4, "R11 minimum hold", n_sw - b_sw, 4);
    clear_status();
  endtask

  task automatic t_watchdog();
    wdog_to_nmi = 1'b0; mark();
    wdog_expire = 1'b1; run(1); wdog_expire = 1'b0; run(10);
    chk(n_hw - b_hw == 4, "R8 watchdog hw reset", n_hw - b_hw, 4);
    chk(status_o == 4'b1000, "R8 watchdog cause", status_o, 8);
    clear_status();
    wdog_to_nmi = 1'b1; mark();
    wdog_expire = 1'b1; run(1); wdog_expire = 1'b0; run(10);
    chk(n_nmi - b_nmi == 1, "R8 nmi single pulse", n_nmi - b_nmi, 1);
    chk(n_hw == b_hw, "R8 nmi no reset", n_hw - b_hw, 0);
    chk(status_o == 4'h0, "R8 nmi no cause", status_o, 0);
    wdog_to_nmi = 1'b0;
  endtask

  task automatic t_wake();
    rst_on_wake = 1'b1; mark();
    wake_event = 1'b1; run(1); wake_event = 1'b0; run(10);
    chk(n_hw - b_hw == 4, "R9 wake hw reset", n_hw - b_hw, 4);
    chk(status_o == 4'b0010, "R9 wake cause", status_o, 2);
    clear_status();
    rst_on_wake = 1'b0; mark();
    wake_event = 1'b1; run(1); wake_event = 1'b0; run(10);
    chk(n_hw == b_hw && status_o == 4'h0, "R9 wake ignored when off", n_hw - b_hw, 0);
  endtask

  task automatic t_sticky();
    wdog_expire = 1'b1; run(1); wdog_expire = 1'b0; run(6);
    sw_rst_req = 1'b1; run(1); sw_rst_req = 1'b0; run(6);
    chk(status_o == 4'b1100, "R10 causes accumulate", status_o, 12);
    status_clr_we = 1'b1; status_clr = 4'b1000; run(1);
    status_clr_we = 1'b0; status_clr = 4'h0;
    chk(status_o == 4'b0100, "R10 partial clear", status_o, 4);
    sw_rst_req = 1'b1; status_clr_we = 1'b1; status_clr = 4'b0100; run(1);
    sw_rst_req = 1'b0; status_clr_we = 1'b0; status_clr = 4'h0;
    chk(status_o[2] == 1'b1, "R10 set wins over clear", status_o, 4);
    run(6);
    clear_status();
  endtask

  initial begin
    #(20 * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    supply_ok = 3'b000; ext_rst_i = 1'b0; gpio_i = 8'hFF; gpio_src_en = 1'b0;
    gpio_src_sel = 3'd0; gpio_src_pol = 1'b1; por_delay = 8'd6; hwr_disable = 1'b0;
    sw_rst_req = 1'b0; wdog_expire = 1'b0; wdog_to_nmi = 1'b0; wake_event = 1'b0;
    rst_on_wake = 1'b0; status_clr_we = 1'b0; status_clr = 4'h0;
    run(3);
    t_power_up();
    t_threshold();
    t_gpio();
    t_delay_zero();
    t_hwr_disable();
    t_software();
    t_watchdog();
    t_wake();
    t_sticky();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule